// File: doc/BRIEF.md
# Configurable GPIO Function Controller

This block controls one general-purpose pin from a 16-bit configuration word. In input mode it synchronises the raw pin and can pass it through a stability filter. It then watches the resulting level for rising edges, falling edges and low levels, and turns them into command outputs. Each command output is either a one-clock strobe or a held state flop. A 4-bit function code picks which command the pin drives. Some commands act on the whole device. Others act only on the channels whose bit is set in a 4-bit channel mask.

In output mode the block drives the pin from one internal status bit, chosen by a 4-bit selector. The status inputs, the functions the commands trigger and the bus that writes the configuration word all sit outside this block.

Top module: `gpio_func_ctrl`

## Requirements
- R1: After reset every strobe and held output is 0 except `nvm_wr_ok`, which is 1. `pin_out` and `pin_oe` are 0 while the configuration word is 0.
- R2: With cfg[15]=0, a pin change reaches the command outputs on the third rising clock edge after it is applied: two synchroniser flops, then one output register. A strobe lasts exactly one clock, and a pin pulse only one clock long still produces one strobe.
- R3: With cfg[15]=1, a new synchronised level counts only after it has held for 4 consecutive clocks, which adds 4 clocks of latency. A low pulse of 3 clocks produces no strobe.
- R4: With cfg[0]=0, no pin activity changes any command output.
- R5: The global function code is cfg[4:1]. Code 0000 sets `sleep_req` on a falling edge and clears it on a rising edge. Code 1011 does the same with `chip_rst_req`.
- R6: Code 0010 pulses `fault_stb` and code 0101 pulses `protect_stb`, both on a falling edge only. A rising edge produces no strobe.
- R7: Code 0111 holds `clear_req` high for as long as the pin level is low.
- R8: The channel mask is cfg[8:5], where bit 5+n enables channel n. Code 0011 sets `iout_off[n]` on a falling edge and clears it on a rising edge, and code 0100 does the same with `vout_off[n]`. Both act only on channels whose mask bit is 1.
- R9: Code 1000 pulses `load_stb[n]` for one clock on a falling edge, only on masked-in channels.
- R10: Code 1001 sets `wave_run[n]` on a rising edge and clears it on a falling edge. Code 1010 does the same with `margin_hi[n]`. Both act only on masked-in channels.
- R11: Code 1100 sets `nvm_wr_ok` on a falling edge and clears it on a rising edge. Code 1101 clears `regs_locked` on a falling edge and sets it on a rising edge.
- R12: Function codes 0001, 0110, 1110 and 1111 leave every command output unchanged.
- R13: `pin_oe` follows cfg[13]. `pin_out` is driven from the status bit chosen by cfg[12:9]:
  - 0001 selects `nvm_busy`.
  - 01nn selects `ch_busy[nn]`.
  - 10nn selects `win_cmp[nn]`.
  
  Every other selector code gives 0, and `pin_out` is 0 whenever cfg[13]=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 16 | Configuration word |
| pin_in | input | 1 | Raw pin level, asynchronous |
| nvm_busy | input | 1 | Status: non-volatile memory busy |
| ch_busy | input | NCH | Status: per-channel busy |
| win_cmp | input | NCH | Status: per-channel window comparator |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin output enable |
| sleep_req | output | 1 | Held deep-sleep request |
| chip_rst_req | output | 1 | Held device reset request |
| fault_stb | output | 1 | Fault-dump strobe |
| protect_stb | output | 1 | Protect strobe |
| clear_req | output | 1 | Level clear request |
| nvm_wr_ok | output | 1 | Non-volatile memory writes allowed |
| regs_locked | output | 1 | Register updates locked |
| iout_off | output | NCH | Current output powered down, per channel |
| vout_off | output | NCH | Voltage output powered down, per channel |
| load_stb | output | NCH | Load strobe, per channel |
| wave_run | output | NCH | Waveform generation running, per channel |
| margin_hi | output | NCH | 1 = margin high, 0 = margin low, per channel |

## Verification
The bench drives a 3-clock low glitch with the filter on. A filter that counts one clock short would let that glitch through as a fault strobe. A 1-clock pulse with the filter off must still give exactly one strobe, which catches edge logic that needs a settled level.

Falling and rising edges are each applied in turn, so a swapped edge polarity shows up in the held state flops. The lock and write-protect pair is driven both ways, so an inverted reset value or a swapped edge would be caught.

Masks with channels both set and clear are used. A design that ignores the mask would change or pulse the channels outside it. Invalid output selector codes and the output-disabled case must drive the pin low.

// File: rtl/gpio_func_ctrl.sv
module gpio_func_ctrl #(
  parameter int NCH      = 4,
  parameter int FILT_LEN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [15:0]    cfg,
  input  logic           pin_in,
  input  logic           nvm_busy,
  input  logic [NCH-1:0] ch_busy,
  input  logic [NCH-1:0] win_cmp,
  output logic           pin_out,
  output logic           pin_oe,
  output logic           sleep_req,
  output logic           chip_rst_req,
  output logic           fault_stb,
  output logic           protect_stb,
  output logic           clear_req,
  output logic           nvm_wr_ok,
  output logic           regs_locked,
  output logic [NCH-1:0] iout_off,
  output logic [NCH-1:0] vout_off,
  output logic [NCH-1:0] load_stb,
  output logic [NCH-1:0] wave_run,
  output logic [NCH-1:0] margin_hi
);

  localparam int CW = $clog2(FILT_LEN) + 1;

  localparam logic [3:0] F_SLEEP = 4'h0;
  localparam logic [3:0] F_FAULT = 4'h2;
  localparam logic [3:0] F_IOUT  = 4'h3;
  localparam logic [3:0] F_VOUT  = 4'h4;
  localparam logic [3:0] F_PROT  = 4'h5;
  localparam logic [3:0] F_CLR   = 4'h7;
  localparam logic [3:0] F_LOAD  = 4'h8;
  localparam logic [3:0] F_WAVE  = 4'h9;
  localparam logic [3:0] F_MARG  = 4'hA;
  localparam logic [3:0] F_RST   = 4'hB;
  localparam logic [3:0] F_NVM   = 4'hC;
  localparam logic [3:0] F_LOCK  = 4'hD;

  logic           in_en, gf_en, out_en;
  logic [3:0]     func, osel;
  logic [NCH-1:0] mask;

  assign in_en  = cfg[0];
  assign func   = cfg[4:1];
  assign mask   = cfg[5 +: NCH];
  assign osel   = cfg[12:9];
  assign out_en = cfg[13];
  assign gf_en  = cfg[15];

  // output path
  logic st_sel;

  always_comb begin
    st_sel = 1'b0;
    casez (osel)
      4'b0001: st_sel = nvm_busy;
      4'b01??: st_sel = ch_busy[osel[1:0]];
      4'b10??: st_sel = win_cmp[osel[1:0]];
      default: st_sel = 1'b0;
    endcase
  end

  assign pin_oe  = out_en;
  assign pin_out = out_en & st_sel;

  // input path: synchroniser, stability filter, edge detect
  logic [1:0]    sync_q;
  logic          filt_q, prev_q, lvl, rise, fall;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], pin_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else if (sync_q[1] == filt_q) begin
      cnt_q  <= '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      filt_q <= sync_q[1];
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign lvl = gf_en ? filt_q : sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;
  end

  assign rise = in_en &  lvl & ~prev_q;
  assign fall = in_en & ~lvl &  prev_q;

  // command outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_req    <= 1'b0;
      chip_rst_req <= 1'b0;
      fault_stb    <= 1'b0;
      protect_stb  <= 1'b0;
      clear_req    <= 1'b0;
      nvm_wr_ok    <= 1'b1;
      regs_locked  <= 1'b0;
      iout_off     <= '0;
      vout_off     <= '0;
      load_stb     <= '0;
      wave_run     <= '0;
      margin_hi    <= '0;
    end else begin
      fault_stb   <= fall && (func == F_FAULT);
      protect_stb <= fall && (func == F_PROT);
      clear_req   <= in_en && (func == F_CLR) && !lvl;

      if (func == F_SLEEP) begin
        if (fall)      sleep_req <= 1'b1;
        else if (rise) sleep_req <= 1'b0;
      end
      if (func == F_RST) begin
        if (fall)      chip_rst_req <= 1'b1;
        else if (rise) chip_rst_req <= 1'b0;
      end
      if (func == F_NVM) begin
        if (fall)      nvm_wr_ok <= 1'b1;
        else if (rise) nvm_wr_ok <= 1'b0;
      end
      if (func == F_LOCK) begin
        if (fall)      regs_locked <= 1'b0;
        else if (rise) regs_locked <= 1'b1;
      end

      for (int n = 0; n < NCH; n++) begin
        load_stb[n] <= fall && mask[n] && (func == F_LOAD);
        if (mask[n]) begin
          if (func == F_IOUT) begin
            if (fall)      iout_off[n] <= 1'b1;
            else if (rise) iout_off[n] <= 1'b0;
          end
          if (func == F_VOUT) begin
            if (fall)      vout_off[n] <= 1'b1;
            else if (rise) vout_off[n] <= 1'b0;
          end
          if (func == F_WAVE) begin
            if (rise)      wave_run[n] <= 1'b1;
            else if (fall) wave_run[n] <= 1'b0;
          end
          if (func == F_MARG) begin
            if (rise)      margin_hi[n] <= 1'b1;
            else if (fall) margin_hi[n] <= 1'b0;
          end
        end
      end
    end
  end

  // R2
  fault_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_stb |=> !fault_stb);

  // R3
  filt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> ($past(sync_q[1]) != $past(filt_q)) &&
                         ($past(sync_q[1], 2) == $past(sync_q[1])));

  // R9
  load_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb & ~$past(mask)) == '0);

  // R11
  lock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_locked) |-> $past(in_en) && ($past(func) == F_LOCK));

  // R11
  nvm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nvm_wr_ok) |-> $past(in_en) && ($past(func) == F_NVM));

  // R13
  pin_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out |-> pin_oe && (nvm_busy || (|ch_busy) || (|win_cmp)));

endmodule

// File: tb/gpio_func_ctrl_tb.sv
`timescale 1ns/100ps
module gpio_func_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg = '0;
  logic        pin_in = 1'b1;
  logic        nvm_busy = 1'b0;
  logic [3:0]  ch_busy = '0, win_cmp = '0;
  logic        pin_out, pin_oe, sleep_req, chip_rst_req, fault_stb, protect_stb;
  logic        clear_req, nvm_wr_ok, regs_locked;
  logic [3:0]  iout_off, vout_off, load_stb, wave_run, margin_hi;

  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_func_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .pin_in(pin_in),
    .nvm_busy(nvm_busy), .ch_busy(ch_busy), .win_cmp(win_cmp),
    .pin_out(pin_out), .pin_oe(pin_oe), .sleep_req(sleep_req),
    .chip_rst_req(chip_rst_req), .fault_stb(fault_stb), .protect_stb(protect_stb),
    .clear_req(clear_req), .nvm_wr_ok(nvm_wr_ok), .regs_locked(regs_locked),
    .iout_off(iout_off), .vout_off(vout_off), .load_stb(load_stb),
    .wave_run(wave_run), .margin_hi(margin_hi)
  );

  // {oe, sel[3:0], nvm, ch[3:0], win[3:0], expected}
  localparam logic [14:0] MUXV [14] = '{
    {1'b1, 4'h1, 1'b1, 4'h0, 4'h0, 1'b1},
    {1'b1, 4'h1, 1'b0, 4'hF, 4'hF, 1'b0},
    {1'b1, 4'h4, 1'b0, 4'h1, 4'h0, 1'b1},
    {1'b1, 4'h5, 1'b0, 4'hD, 4'hF, 1'b0},
    {1'b1, 4'h6, 1'b0, 4'h4, 4'h0, 1'b1},
    {1'b1, 4'h7, 1'b0, 4'h8, 4'h0, 1'b1},
    {1'b1, 4'h8, 1'b0, 4'h0, 4'h1, 1'b1},
    {1'b1, 4'h9, 1'b1, 4'hF, 4'hD, 1'b0},
    {1'b1, 4'hA, 1'b0, 4'h0, 4'h4, 1'b1},
    {1'b1, 4'hB, 1'b0, 4'h0, 4'h8, 1'b1},
    {1'b1, 4'h0, 1'b1, 4'hF, 4'hF, 1'b0},
    {1'b1, 4'h2, 1'b1, 4'hF, 4'hF, 1'b0},
    {1'b1, 4'hF, 1'b1, 4'hF, 4'hF, 1'b0},
    {1'b0, 4'h1, 1'b1, 4'hF, 4'hF, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pin_to(input logic v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg = v;
    wait_n(2);
  endtask

  task automatic watch(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fault_stb || protect_stb || (|load_stb)) hits++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int hits;
    logic [19:0] snap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    chk("R1 globals", {sleep_req, chip_rst_req, fault_stb, protect_stb, clear_req,
                       nvm_wr_ok, regs_locked, pin_out, pin_oe}, 9'b000001000);
    chk("R1 channels", {iout_off, vout_off, load_stb, wave_run, margin_hi}, 20'h0);

    // R13 output mux table
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      cfg = {2'b00, MUXV[i][14], MUXV[i][13:10], 9'b0};
      nvm_busy = MUXV[i][9];
      ch_busy  = MUXV[i][8:5];
      win_cmp  = MUXV[i][4:1];
      #1;
      chk("R13 pin_out", pin_out, MUXV[i][0]);
      chk("R13 pin_oe", pin_oe, MUXV[i][14]);
    end
    @(negedge clk);
    nvm_busy = 1'b0; ch_busy = '0; win_cmp = '0;

    // R4 input mode disabled
    set_cfg(16'h0000);
    pin_to(0); wait_n(4);
    chk("R4 sleep ignored", sleep_req, 0);
    pin_to(1); wait_n(4);
    set_cfg(16'h0004);
    pin_to(0); watch(6, hits);
    chk("R4 no strobe", hits, 0);
    pin_to(1); wait_n(4);

    // R6 fault / protect on falling edge only, R2 timing
    set_cfg(16'h0005);
    pin_to(0); wait_n(2);
    chk("R2 fault not early", fault_stb, 0);
    wait_n(1);
    chk("R6 fault strobe", fault_stb, 1);
    wait_n(1);
    chk("R2 fault one clock", fault_stb, 0);
    pin_to(1); watch(6, hits);
    chk("R6 rise no strobe", hits, 0);
    // R2 one-clock pulse still seen
    pin_to(0); @(negedge clk); pin_in = 1'b1;
    watch(6, hits);
    chk("R2 short pulse", hits, 1);
    set_cfg(16'h000B);
    pin_to(0); wait_n(3);
    chk("R6 protect strobe", protect_stb, 1);
    wait_n(1);
    chk("R6 protect one clock", protect_stb, 0);
    pin_to(1); wait_n(4);

    // R7 clear level
    set_cfg(16'h000F);
    pin_to(0); wait_n(3);
    chk("R7 clear asserted", clear_req, 1);
    wait_n(5);
    chk("R7 clear held", clear_req, 1);
    pin_to(1); wait_n(3);
    chk("R7 clear released", clear_req, 0);

    // R5 sleep and device reset
    set_cfg(16'h0001);
    pin_to(0); wait_n(3);
    chk("R5 sleep on fall", sleep_req, 1);
    pin_to(1); wait_n(3);
    chk("R5 sleep off on rise", sleep_req, 0);
    set_cfg(16'h0017);
    pin_to(0); wait_n(3);
    chk("R5 reset on fall", chip_rst_req, 1);
    pin_to(1); wait_n(3);
    chk("R5 reset off on rise", chip_rst_req, 0);

    // R8 masked power down
    set_cfg(16'h00A7);
    pin_to(0); wait_n(3);
    chk("R8 iout masked", iout_off, 4'b0101);
    chk("R8 vout untouched", vout_off, 4'b0000);
    pin_to(1); wait_n(3);
    chk("R8 iout up", iout_off, 4'b0000);
    set_cfg(16'h0149);
    pin_to(0); wait_n(3);
    chk("R8 vout masked", vout_off, 4'b1010);
    chk("R8 iout untouched", iout_off, 4'b0000);
    pin_to(1); wait_n(3);
    chk("R8 vout up", vout_off, 4'b0000);

    // R9 masked load strobe
    set_cfg(16'h0071);
    pin_to(0); wait_n(3);
    chk("R9 load strobe", load_stb, 4'b0011);
    wait_n(1);
    chk("R9 load one clock", load_stb, 4'b0000);
    pin_to(1); wait_n(3);
    chk("R9 no load on rise", load_stb, 4'b0000);

    // R10 waveform and margin
    set_cfg(16'h01F3);
    pin_to(0); wait_n(3);
    chk("R10 wave stop", wave_run, 4'h0);
    pin_to(1); wait_n(3);
    chk("R10 wave start", wave_run, 4'hF);
    set_cfg(16'h0115);
    pin_to(0); wait_n(3);
    chk("R10 margin low", margin_hi, 4'h0);
    chk("R10 wave kept", wave_run, 4'hF);
    pin_to(1); wait_n(3);
    chk("R10 margin high masked", margin_hi, 4'b1000);
    pin_to(0); wait_n(3);
    chk("R10 margin back low", margin_hi, 4'b0000);
    pin_to(1); wait_n(3);

    // R11 write protect and lock
    set_cfg(16'h0019);
    pin_to(0); wait_n(3);
    chk("R11 nvm allowed", nvm_wr_ok, 1);
    pin_to(1); wait_n(3);
    chk("R11 nvm blocked", nvm_wr_ok, 0);
    pin_to(0); wait_n(3);
    chk("R11 nvm reallowed", nvm_wr_ok, 1);
    pin_to(1); wait_n(3);
    set_cfg(16'h001B);
    pin_to(0); wait_n(3);
    chk("R11 unlocked", regs_locked, 0);
    pin_to(1); wait_n(3);
    chk("R11 locked", regs_locked, 1);
    chk("R11 nvm kept", nvm_wr_ok, 0);
    pin_to(0); wait_n(3);
    chk("R11 unlocked again", regs_locked, 0);

    // R12 unused function code
    set_cfg(16'h000D);
    snap = {sleep_req, chip_rst_req, nvm_wr_ok, regs_locked,
            iout_off, vout_off, wave_run, margin_hi};
    pin_to(1); watch(5, hits);
    chk("R12 no strobe rise", hits, 0);
    pin_to(0); watch(5, hits);
    chk("R12 no strobe fall", hits, 0);
    chk("R12 no clear", clear_req, 0);
    pin_to(1); wait_n(4);
    chk("R12 state kept", {sleep_req, chip_rst_req, nvm_wr_ok, regs_locked,
                           iout_off, vout_off, wave_run, margin_hi}, snap);

    // R3 stability filter
    set_cfg(16'h8005);
    pin_to(0); wait_n(3); pin_in = 1'b1;
    watch(12, hits);
    chk("R3 glitch rejected", hits, 0);
    pin_to(0); wait_n(6);
    chk("R3 not yet", fault_stb, 0);
    wait_n(1);
    chk("R3 filtered strobe", fault_stb, 1);
    wait_n(1);
    chk("R3 strobe one clock", fault_stb, 0);
    pin_to(1); wait_n(8);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule